// File: doc/BRIEF.md
# Three-Level Radix Page-Table Walker

This block turns a 64-bit virtual address into a 56-bit physical address. It walks a three-level radix page table that is held in memory. A requester raises `req_valid` with the address, the access kind and the privilege, and keeps these inputs steady until `done` pulses. The walker starts at the page number given on `base_ppn`. It fetches one 64-bit entry per level over a valid/ready read port, with a single read in flight at a time. It then reports either the physical address or a fault.

Each level consumes nine bits of the virtual page number, taken from the most significant group down to the least significant. An entry must be present to be followed. An entry that has none of the read, write or execute bits set points to the next table. Any other present entry is a leaf, and it is legal only at the last level. At the leaf, the access kind and the privilege are checked against the entry's permission bits.

Top module: `radix_walk_xlate`

## Requirements
- R1: While reset is asserted and after it is released, `done` and `mem_req_valid` are low until a request arrives.
- R2: Each entry read uses the address {table page number, 9-bit index, 3'b000}. The first read uses `base_ppn` with index vaddr[38:30]. The second uses the first entry's PPN with vaddr[29:21]. The third uses the second entry's PPN with vaddr[20:12].
- R3: `mem_req_valid` stays high with a stable `mem_req_addr` until `mem_req_ready` is seen. No new read is issued while a response is still owed.
- R4: A successful walk ends with `done` high, `fault` low and `paddr` = {leaf PTE bits 53:10, vaddr[11:0]}.
- R5: An entry with bit 0 (present) clear at any level ends the walk with a fault, and no further reads follow.
- R6: A pointer entry (bits 3:1 all zero) at the last level faults. A leaf entry (any of bits 3:1 set) at the first or second level also faults.
- R7: Access kinds are 2'b00 load, 2'b01 store, 2'b10 fetch and 2'b11 reserved. A load needs bit 1 (R), a store needs bit 2 (W) and a fetch needs bit 3 (X). The reserved kind always faults.
- R8: A user access (`req_user`=1) needs bit 4 (U) set. A supervisor access to a leaf with U set faults.
- R9: Virtual address bits 63:39 have no effect on the reads or on the result.
- R10: `done` is a single-cycle pulse. A successful walk makes exactly three reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request, held until `done` |
| req_vaddr | input | 64 | Virtual address to translate |
| req_kind | input | 2 | Access kind: 00 load, 01 store, 10 fetch, 11 reserved |
| req_user | input | 1 | 1 = user-mode access, 0 = supervisor |
| base_ppn | input | 44 | Page number of the root table |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_addr | output | 56 | Byte address of the entry to read |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_rsp_valid | input | 1 | Read data is returned |
| mem_rsp_data | input | 64 | Entry contents |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Walk failed; valid while `done` is high |
| paddr | output | 56 | Physical address; valid while `done` is high and `fault` is low |

## Verification
A corrupted level counter or table page number appears at the ports on the very next read. It produces a wrong entry address or the wrong number of reads, so it is caught within a few cycles of the bad update. A wrong walk state shows as a read issued while a response is still owed, a `done` pulse longer than one cycle, or an early or missing completion. These are visible at the first memory handshake or completion that follows. Wrong decoding of an entry shows only at completion, as a fault flag or physical address that does not match the table the bench built.

// File: rtl/rwx_pkg.sv
`timescale 1ns/1ps
package rwx_pkg;
    localparam int OFF_BITS   = 12;
    localparam int IDX_BITS   = 9;
    localparam int LEVELS     = 3;
    localparam int VPN_BITS   = IDX_BITS * LEVELS;
    localparam int VA_BITS    = VPN_BITS + OFF_BITS;
    localparam int PPN_BITS   = 44;
    localparam int PA_BITS    = PPN_BITS + OFF_BITS;
    localparam int PTE_BITS   = 64;
    localparam int PTE_LOG2B  = 3;
    localparam int PPN_LSB    = 10;
    localparam int LVL_BITS   = $clog2(LEVELS);

    localparam int FLG_PRESENT = 0;
    localparam int FLG_READ    = 1;
    localparam int FLG_WRITE   = 2;
    localparam int FLG_EXEC    = 3;
    localparam int FLG_USER    = 4;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'b00,
        ACC_STORE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_kind_e;

    typedef enum logic [1:0] {
        W_IDLE,
        W_ISSUE,
        W_AWAIT,
        W_REPORT
    } walk_state_e;

    typedef struct packed {
        walk_state_e          st;
        logic [LVL_BITS-1:0]  lvl;
        logic [PPN_BITS-1:0]  tbl;
        logic                 done;
        logic                 fault;
        logic [PA_BITS-1:0]   pa;
    } walk_regs_t;

    localparam walk_regs_t WALK_RST = '{
        st:    W_IDLE,
        lvl:   '0,
        tbl:   '0,
        done:  1'b0,
        fault: 1'b0,
        pa:    '0
    };
endpackage

// File: rtl/rwx_index_sel.sv
`timescale 1ns/1ps
module rwx_index_sel #(
    parameter int IDX_W  = 9,
    parameter int NLEVEL = 3,
    parameter int LVL_W  = 2
) (
    input  logic [IDX_W*NLEVEL-1:0] vpn,
    input  logic [LVL_W-1:0]        lvl,
    output logic [IDX_W-1:0]        idx
);
    localparam int SLOTS = 2 ** LVL_W;

    logic [IDX_W-1:0] slot [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        if (g < NLEVEL) begin : g_used
            assign slot[g] = vpn[g*IDX_W +: IDX_W];
        end else begin : g_pad
            assign slot[g] = '0;
        end
    end

    assign idx = slot[lvl];
endmodule

// File: rtl/rwx_pte_decode.sv
`timescale 1ns/1ps
module rwx_pte_decode
    import rwx_pkg::*;
(
    input  logic [PTE_BITS-1:0] pte,
    output logic                present,
    output logic                leaf,
    output logic                can_rd,
    output logic                can_wr,
    output logic                can_ex,
    output logic                usr_pg,
    output logic [PPN_BITS-1:0] ppn
);
    logic unused_pte_bits;

    assign present = pte[FLG_PRESENT];
    assign can_rd  = pte[FLG_READ];
    assign can_wr  = pte[FLG_WRITE];
    assign can_ex  = pte[FLG_EXEC];
    assign usr_pg  = pte[FLG_USER];
    assign leaf    = can_rd | can_wr | can_ex;
    assign ppn     = pte[PPN_LSB +: PPN_BITS];

    assign unused_pte_bits = ^{pte[PTE_BITS-1:PPN_LSB+PPN_BITS], pte[PPN_LSB-1:FLG_USER+1]};
endmodule

// File: rtl/rwx_perm_check.sv
`timescale 1ns/1ps
module rwx_perm_check
    import rwx_pkg::*;
(
    input  logic [1:0] kind,
    input  logic       user_acc,
    input  logic       can_rd,
    input  logic       can_wr,
    input  logic       can_ex,
    input  logic       usr_pg,
    output logic       allow
);
    logic kind_ok;
    logic priv_ok;

    always_comb begin
        unique case (acc_kind_e'(kind))
            ACC_LOAD:  kind_ok = can_rd;
            ACC_STORE: kind_ok = can_wr;
            ACC_FETCH: kind_ok = can_ex;
            default:   kind_ok = 1'b0;
        endcase
        priv_ok = user_acc ? usr_pg : ~usr_pg;
        allow   = kind_ok & priv_ok;
    end
endmodule

// File: rtl/radix_walk_xlate.sv
`timescale 1ns/1ps
module radix_walk_xlate
    import rwx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [63:0]         req_vaddr,
    input  logic [1:0]          req_kind,
    input  logic                req_user,
    input  logic [PPN_BITS-1:0] base_ppn,
    output logic                mem_req_valid,
    output logic [PA_BITS-1:0]  mem_req_addr,
    input  logic                mem_req_ready,
    input  logic                mem_rsp_valid,
    input  logic [PTE_BITS-1:0] mem_rsp_data,
    output logic                done,
    output logic                fault,
    output logic [PA_BITS-1:0]  paddr
);
    walk_regs_t r_q, r_d;

    logic [IDX_BITS-1:0] cur_idx;
    logic                pte_present, pte_leaf;
    logic                pte_rd, pte_wr, pte_ex, pte_usr;
    logic [PPN_BITS-1:0] pte_ppn;
    logic                perm_allow;
    logic                unused_va_hi;

    assign unused_va_hi = ^req_vaddr[63:VA_BITS];

    rwx_index_sel #(
        .IDX_W  (IDX_BITS),
        .NLEVEL (LEVELS),
        .LVL_W  (LVL_BITS)
    ) idx_sel_i (
        .vpn (req_vaddr[OFF_BITS +: VPN_BITS]),
        .lvl (r_q.lvl),
        .idx (cur_idx)
    );

    rwx_pte_decode pte_dec_i (
        .pte     (mem_rsp_data),
        .present (pte_present),
        .leaf    (pte_leaf),
        .can_rd  (pte_rd),
        .can_wr  (pte_wr),
        .can_ex  (pte_ex),
        .usr_pg  (pte_usr),
        .ppn     (pte_ppn)
    );

    rwx_perm_check perm_i (
        .kind     (req_kind),
        .user_acc (req_user),
        .can_rd   (pte_rd),
        .can_wr   (pte_wr),
        .can_ex   (pte_ex),
        .usr_pg   (pte_usr),
        .allow    (perm_allow)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            W_IDLE: begin
                if (req_valid) begin
                    r_d.lvl = LVL_BITS'(LEVELS - 1);
                    r_d.tbl = base_ppn;
                    r_d.st  = W_ISSUE;
                end
            end
            W_ISSUE: begin
                if (mem_req_ready) begin
                    r_d.st = W_AWAIT;
                end
            end
            W_AWAIT: begin
                if (mem_rsp_valid) begin
                    if (!pte_present) begin
                        r_d.st    = W_REPORT;
                        r_d.done  = 1'b1;
                        r_d.fault = 1'b1;
                        r_d.pa    = '0;
                    end else if (pte_leaf) begin
                        r_d.st   = W_REPORT;
                        r_d.done = 1'b1;
                        if ((r_q.lvl != '0) || !perm_allow) begin
                            r_d.fault = 1'b1;
                            r_d.pa    = '0;
                        end else begin
                            r_d.fault = 1'b0;
                            r_d.pa    = {pte_ppn, req_vaddr[OFF_BITS-1:0]};
                        end
                    end else if (r_q.lvl == '0) begin
                        r_d.st    = W_REPORT;
                        r_d.done  = 1'b1;
                        r_d.fault = 1'b1;
                        r_d.pa    = '0;
                    end else begin
                        r_d.lvl = r_q.lvl - 1'b1;
                        r_d.tbl = pte_ppn;
                        r_d.st  = W_ISSUE;
                    end
                end
            end
            default: begin
                r_d.st = W_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= WALK_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_req_valid = (r_q.st == W_ISSUE);
    assign mem_req_addr  = {r_q.tbl, cur_idx, {PTE_LOG2B{1'b0}}};
    assign done          = r_q.done;
    assign fault         = r_q.fault;
    assign paddr         = r_q.pa;
endmodule

// File: rtl/rwx_walk_checker.sv
`timescale 1ns/1ps
module rwx_walk_checker
    import rwx_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [63:0]        req_vaddr,
    input logic               mem_req_valid,
    input logic               mem_req_ready,
    input logic [PA_BITS-1:0] mem_req_addr,
    input logic               mem_rsp_valid,
    input logic               done,
    input logic               fault,
    input logic [PA_BITS-1:0] paddr
);
    logic [2:0] rd_cnt_q;
    logic       owed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_cnt_q <= '0;
            owed_q   <= 1'b0;
        end else begin
            if (done) begin
                rd_cnt_q <= '0;
            end else if (mem_req_valid && mem_req_ready && rd_cnt_q != 3'd7) begin
                rd_cnt_q <= rd_cnt_q + 3'd1;
            end
            if (mem_req_valid && mem_req_ready) begin
                owed_q <= 1'b1;
            end else if (mem_rsp_valid) begin
                owed_q <= 1'b0;
            end
        end
    end

    // R3: a stalled read keeps its address
    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R3: no read while a response is still owed
    p_one_outstanding_r3: assert property (@(posedge clk) disable iff (!rst_n)
        owed_q |-> !mem_req_valid);

    // R4: page offset passes through
    p_offset_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done && !fault |-> paddr[OFF_BITS-1:0] == req_vaddr[OFF_BITS-1:0]);

    // R10: single-cycle completion
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: three reads on success
    p_three_reads_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done && !fault |-> rd_cnt_q == 3'(LEVELS));

    // R5: never more reads than levels
    p_read_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cnt_q <= 3'(LEVELS));

    // R1: no completion while idle with a read on the port
    p_quiet_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req_valid);
endmodule

bind radix_walk_xlate rwx_walk_checker chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_vaddr     (req_vaddr),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .done          (done),
    .fault         (fault),
    .paddr         (paddr)
);

// File: tb/radix_walk_xlate_tb_top.sv
`timescale 1ns/1ps
module radix_walk_xlate_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        req_user = 1'b0;
    logic [43:0] base_ppn = '0;
    logic        mem_req_valid;
    logic [55:0] mem_req_addr;
    logic        mem_req_ready = 1'b0;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        done;
    logic        fault;
    logic [55:0] paddr;

    int nchk = 0;
    int nerr = 0;

    logic [63:0] pmem [logic [55:0]];
    logic [55:0] rd_addr [8];
    int          rd_n = 0;
    logic [55:0] exp_addr [3];
    int          exp_n;
    logic [43:0] tbl_mid, tbl_last;

    always #5 clk = ~clk;

    radix_walk_xlate dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_vaddr     (req_vaddr),
        .req_kind      (req_kind),
        .req_user      (req_user),
        .base_ppn      (base_ppn),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .done          (done),
        .fault         (fault),
        .paddr         (paddr)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_pte(input logic [43:0] ppn, input logic [4:0] flg);
        logic [9:0] hi;
        logic [4:0] mid;
        hi  = 10'($urandom);
        mid = 5'($urandom);
        return {hi, ppn, mid, flg};
    endfunction

    // Builds one three-level path for va; flags given per level (root first).
    task automatic setup(input logic [63:0] va, input logic [4:0] f2,
                         input logic [4:0] f1, input logic [4:0] f0,
                         input logic [43:0] leaf_ppn);
        logic [43:0] rt;
        pmem.delete();
        rt       = {44'({$urandom, $urandom})} & ~44'h3;
        tbl_mid  = {44'({$urandom, $urandom})} & ~44'h3 | 44'h1;
        tbl_last = {44'({$urandom, $urandom})} & ~44'h3 | 44'h2;
        base_ppn = rt;
        pmem[{rt, va[38:30], 3'b000}]       = mk_pte(tbl_mid, f2);
        pmem[{tbl_mid, va[29:21], 3'b000}]  = mk_pte(tbl_last, f1);
        pmem[{tbl_last, va[20:12], 3'b000}] = mk_pte(leaf_ppn, f0);
    endtask

    task automatic ref_walk(input logic [63:0] va, input logic [1:0] kind, input logic usr,
                            output logic efault, output logic [55:0] epa, output string why);
        logic [43:0] tb;
        logic [63:0] e;
        logic        ok;
        tb = base_ppn; exp_n = 0; efault = 1'b0; epa = '0; why = "R4";
        for (int lv = 2; lv >= 0; lv--) begin
            logic [8:0] ix;
            ix = va[12 + 9*lv +: 9];
            exp_addr[exp_n] = {tb, ix, 3'b000};
            e = pmem.exists(exp_addr[exp_n]) ? pmem[exp_addr[exp_n]] : 64'h0;
            exp_n++;
            if (!e[0]) begin efault = 1'b1; why = "R5"; return; end
            if (e[3:1] != 3'b000) begin
                if (lv != 0) begin efault = 1'b1; why = "R6"; return; end
                case (kind)
                    2'b00: ok = e[1];
                    2'b01: ok = e[2];
                    2'b10: ok = e[3];
                    default: ok = 1'b0;
                endcase
                if (!ok) begin efault = 1'b1; why = "R7"; return; end
                if (usr != e[4]) begin efault = 1'b1; why = "R8"; return; end
                epa = {e[53:10], va[11:0]};
                return;
            end
            if (lv == 0) begin efault = 1'b1; why = "R6"; return; end
            tb = e[53:10];
        end
    endtask

    // Memory responder: random ready stalls and response latency.
    initial begin
        bit          pend = 0;
        int          lat = 0;
        bit          seen = 0;
        logic [55:0] seen_a = '0;
        logic [55:0] acc_a = '0;
        forever begin
            @(negedge clk);
            mem_req_ready = 1'b0;
            mem_rsp_valid = 1'b0;
            if (!rst_n) begin
                pend = 0; seen = 0;
            end else if (pend) begin
                if (mem_req_valid) chk(1'b0, "R3", "read while response owed", 64'(mem_req_addr), 64'h0);
                if (lat == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = pmem.exists(acc_a) ? pmem[acc_a] : 64'h0;
                    pend = 0;
                end else begin
                    lat--;
                end
            end else if (mem_req_valid) begin
                if (!seen) begin
                    seen = 1; seen_a = mem_req_addr;
                end else if (mem_req_addr != seen_a) begin
                    chk(1'b0, "R3", "address moved during stall", 64'(mem_req_addr), 64'(seen_a));
                end
                if ($urandom % 3 != 0) begin
                    mem_req_ready = 1'b1;
                    acc_a = mem_req_addr;
                    pend = 1; lat = int'($urandom % 3); seen = 0;
                    if (rd_n < 8) rd_addr[rd_n] = mem_req_addr;
                    rd_n++;
                end
            end
        end
    end

    task automatic run(input logic [63:0] va, input logic [1:0] kind, input logic usr,
                       input string tag);
        logic        efault;
        logic [55:0] epa;
        string       why;
        int          cyc;
        ref_walk(va, kind, usr, efault, epa, why);
        if (tag != "") why = tag;
        rd_n = 0;
        @(negedge clk);
        req_vaddr = va; req_kind = kind; req_user = usr; req_valid = 1'b1;
        cyc = 0;
        while (!done && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
        if (cyc >= 200) begin
            chk(1'b0, why, "watchdog: no done", 64'(cyc), 64'd200);
        end else begin
            chk(fault == efault, why, "fault flag", 64'(fault), 64'(efault));
            if (!efault) chk(paddr == epa, "R4", "physical address", 64'(paddr), 64'(epa));
            chk(rd_n == exp_n, efault ? "R5" : "R10", "read count", 64'(rd_n), 64'(exp_n));
            for (int i = 0; i < exp_n && i < rd_n; i++)
                chk(rd_addr[i] == exp_addr[i], "R2", "entry address", 64'(rd_addr[i]), 64'(exp_addr[i]));
        end
        req_valid = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R10", "done longer than one cycle", 64'(done), 64'h0);
    endtask

    function automatic logic [4:0] rnd_ptr();
        int r;
        r = int'($urandom % 12);
        if (r == 0) return 5'b00000;
        if (r == 1) return 5'b00011;
        return {1'($urandom), 4'b0001};
    endfunction

    function automatic logic [4:0] rnd_leaf();
        int r;
        r = int'($urandom % 12);
        if (r == 0) return 5'($urandom) & 5'b11110;
        if (r == 1) return 5'b00001;
        return {1'($urandom), 3'(1 + $urandom % 7), 1'b1};
    endfunction

    initial begin
        logic [63:0] va;
        void'($urandom(32'd2024));
        repeat (3) begin
            @(negedge clk);
            chk(done == 1'b0 && mem_req_valid == 1'b0, "R1", "outputs in reset",
                64'({done, mem_req_valid}), 64'h0);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(done == 1'b0 && mem_req_valid == 1'b0, "R1", "outputs after reset",
            64'({done, mem_req_valid}), 64'h0);

        // R4: clean supervisor load
        va = 64'h0000_0041_2345_6ABC;
        setup(va, 5'b00001, 5'b00001, 5'b00011, 44'hABC_DEF0_1234);
        run(va, 2'b00, 1'b0, "R4");
        // R9: upper bits flipped, same tables
        run(va | 64'hFFFF_FF80_0000_0000, 2'b00, 1'b0, "R9");
        run(va ^ 64'h5A5A_5A00_0000_0000, 2'b00, 1'b0, "R9");
        // R7: store without W, fetch without X, reserved kind
        run(va, 2'b01, 1'b0, "R7");
        run(va, 2'b10, 1'b0, "R7");
        setup(va, 5'b00001, 5'b00001, 5'b01111, 44'h1);
        run(va, 2'b11, 1'b0, "R7");
        // R8: user on supervisor page, supervisor on user page
        run(va, 2'b01, 1'b1, "R8");
        setup(va, 5'b00001, 5'b00001, 5'b10011, 44'h2);
        run(va, 2'b00, 1'b0, "R8");
        run(va, 2'b00, 1'b1, "R8");
        // R5: absent entry at mid and root level
        setup(va, 5'b00001, 5'b11110, 5'b00011, 44'h3);
        run(va, 2'b00, 1'b0, "R5");
        setup(va, 5'b00000, 5'b00001, 5'b00011, 44'h3);
        run(va, 2'b00, 1'b0, "R5");
        // R6: pointer at last level, leaf at root and mid level
        setup(va, 5'b00001, 5'b00001, 5'b00001, 44'h4);
        run(va, 2'b00, 1'b0, "R6");
        setup(va, 5'b00011, 5'b00001, 5'b00011, 44'h4);
        run(va, 2'b00, 1'b0, "R6");
        setup(va, 5'b00001, 5'b01011, 5'b00011, 44'h4);
        run(va, 2'b10, 1'b0, "R6");

        // Random mix
        for (int n = 0; n < 300; n++) begin
            va = {$urandom, $urandom};
            setup(va, rnd_ptr(), rnd_ptr(), rnd_leaf(), 44'({$urandom, $urandom}));
            run(va, 2'($urandom), 1'($urandom), "");
        end

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        #1_900_000;
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule